// File: doc/BRIEF.md
# Four-Lane Fixed-Point Shader Instruction Unit

This block executes one 32-bit vector instruction at a time on four-lane operands. Each lane is a 24-bit signed fixed-point number with 16 fraction bits. The instruction word names an opcode, one destination, two source registers and an index into a 32-entry descriptor table. The descriptor word at that index holds three things: a per-lane source selection pattern for each operand, a negate flag for the first operand, and a per-lane write enable for the result.

Operands come from three banks: input, temporary and uniform. The result goes to the output bank or to the temporary bank. The supported operations are lane-wise add, multiply, minimum, maximum and move, plus three- and four-term dot products. Any other opcode, and any destination index with no defined target, is rejected: it writes nothing and raises a one-cycle flag.

A system loads inputs and uniforms through a load port, writes descriptors through their own port, and issues instructions over a valid/ready handshake. It reads the output and temporary banks back through a combinational read port.

Top module: `vshader_exec`

## Requirements
- R1: Opcode is in_instr[31:26]. Supported: 0x00 lane-wise add, 0x08 lane-wise multiply, 0x0C signed maximum, 0x0D signed minimum, 0x13 move of operand A, 0x01 three-lane dot product, 0x02 four-lane dot product.
- R2: Source A index is in_instr[18:12] (7 bits), source B index is in_instr[11:7] (5 bits). Index ranges and targets:
  - 0x00-0x0F: input register n.
  - 0x10-0x1F: temporary register n-0x10.
  - 0x20 and above (source A only): uniform register n-0x20. Uniform indices 0 through 95 are all reachable.
- R3: Destination index is in_instr[25:21]. Values 0x00-0x07 write output register n. Values 0x10-0x1F write temporary register n-0x10.
- R4: in_instr[4:0] selects one of 32 descriptor words. A descriptor written on desc_we at one clock edge is used by an instruction accepted at the next edge or later.
- R5: Descriptor lane selectors use 0=x, 1=y, 2=z, 3=w.
  - Operand A selectors for result lanes x, y, z, w sit at bits 12:11, 10:9, 8:7, 6:5.
  - Operand B selectors for lanes x, y, z, w sit at bits 21:20, 19:18, 17:16, 15:14.
- R6: Descriptor bits 3:0 are the write enables, with bit 3 for lane x and bit 0 for lane w. A disabled lane keeps its previous value.
- R7: Descriptor bit 4 negates operand A after lane selection. The negation saturates, so -(-128.0) becomes 0x7FFFFF.
- R8: Arithmetic uses Q8.16 two's complement with saturation to 0x7FFFFF and 0x800000. Products are shifted right arithmetically by 16 bits.
- R9: Each dot-product term is a saturated product. The terms are summed at full width and saturated once. The scalar result is offered to all four lanes, then gated by the write enables.
- R10: in_ready is low for exactly the cycle after an accepted instruction, so at most one instruction is in flight.
- R11: done is high for one cycle, two clock edges after acceptance. The written result is readable on rd_data in that same cycle.
- R12: The following instructions write no register and pulse illegal together with done:
  - opcodes outside R1 (including 0x0E, 0x0F, 0x21, 0x22, 0x24 and 0x3F);
  - destination indices 0x08-0x0F.
- R13: Load port: ld_bank 0 writes input, 1 writes temporary, 2 writes uniform. Read port: rd_bank 0 reads output, 1 reads temporary. On both ports lane c occupies bits 24c+23:24c, with x as lane 0. Reset clears every bank and the descriptor table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Unit can accept an instruction |
| in_instr | input | 32 | Instruction word |
| desc_we | input | 1 | Descriptor write enable |
| desc_addr | input | 5 | Descriptor entry to write |
| desc_wdata | input | 32 | Descriptor word |
| ld_we | input | 1 | Bank load enable |
| ld_bank | input | 2 | Bank to load (0 input, 1 temporary, 2 uniform) |
| ld_idx | input | 7 | Register index within the bank |
| ld_data | input | 96 | Four-lane value to load |
| rd_bank | input | 1 | Bank to read (0 output, 1 temporary) |
| rd_idx | input | 4 | Register index to read |
| rd_data | output | 96 | Four-lane value read |
| done | output | 1 | Instruction completed |
| illegal | output | 1 | Completed instruction was rejected |

## Verification
The bench targets the following corner cases, each paired with the failure it would expose:
- Saturation at both rails in add, multiply and negation (-(-128.0)). A design that wraps would show a sign-flipped lane.
- A partial write mask on a dot product. Swapping the mask bit order would fill lanes y and w instead of x and z.
- A reversed-lane selection pattern and a broadcast selection on operand B. Transposed selector fields would return the operand unchanged.
- The last uniform register, reached through source A index 0x7F, and a temporary reached through the narrow source B field. An off-by-one bank base would read the wrong register.
- Rejected opcodes and the undefined destination range. A design that still writes would corrupt the output or temporary register the bench reads back afterwards.

// File: rtl/vsx_pkg.sv
package vsx_pkg;
    localparam int CW     = 24;
    localparam int FRAC   = 16;
    localparam int NC     = 4;
    localparam int VW     = NC * CW;
    localparam int WIDE   = 2 * CW + 2;
    localparam int DESC_N = 32;
    localparam int DAW    = $clog2(DESC_N);

    typedef logic signed [CW-1:0] comp_t;
    typedef logic [NC-1:0][CW-1:0] vec_t;

    typedef enum logic [5:0] {
        OP_ADD = 6'h00,
        OP_DP3 = 6'h01,
        OP_DP4 = 6'h02,
        OP_MUL = 6'h08,
        OP_MAX = 6'h0C,
        OP_MIN = 6'h0D,
        OP_MOV = 6'h13
    } op_e;

    typedef struct packed {
        op_e        op;
        vec_t       a;
        vec_t       b;
        logic [3:0] mask;
        logic       dst_tmp;
        logic [3:0] dst_idx;
        logic       bad;
    } issue_t;

    function automatic comp_t clamp(input logic signed [WIDE-1:0] v);
        logic signed [WIDE-1:0] hi;
        logic signed [WIDE-1:0] lo;
        hi = {{(WIDE-CW+1){1'b0}}, {(CW-1){1'b1}}};
        lo = {{(WIDE-CW+1){1'b1}}, {(CW-1){1'b0}}};
        if (v > hi)      return {1'b0, {(CW-1){1'b1}}};
        else if (v < lo) return {1'b1, {(CW-1){1'b0}}};
        else             return v[CW-1:0];
    endfunction

    function automatic comp_t sat_add(input comp_t a, input comp_t b);
        logic signed [WIDE-1:0] ea;
        logic signed [WIDE-1:0] eb;
        ea = a;
        eb = b;
        return clamp(ea + eb);
    endfunction

    function automatic comp_t sat_mul(input comp_t a, input comp_t b);
        logic signed [WIDE-1:0] ea;
        logic signed [WIDE-1:0] eb;
        logic signed [WIDE-1:0] p;
        ea = a;
        eb = b;
        p  = ea * eb;
        return clamp(p >>> FRAC);
    endfunction

    function automatic comp_t sat_neg(input comp_t a);
        logic signed [WIDE-1:0] ea;
        ea = a;
        return clamp(-ea);
    endfunction

    function automatic comp_t dot(input vec_t a, input vec_t b, input int terms);
        logic signed [WIDE-1:0] acc;
        logic signed [WIDE-1:0] ep;
        comp_t p;
        acc = '0;
        for (int k = 0; k < NC; k++) begin
            if (k < terms) begin
                p   = sat_mul(a[k], b[k]);
                ep  = p;
                acc = acc + ep;
            end
        end
        return clamp(acc);
    endfunction

    function automatic logic op_known(input logic [5:0] code);
        case (code)
            OP_ADD, OP_DP3, OP_DP4, OP_MUL, OP_MAX, OP_MIN, OP_MOV: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/vsx_desc_table.sv
module vsx_desc_table import vsx_pkg::*; (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [DAW-1:0] waddr,
    input  logic [31:0]    wdata,
    input  logic [DAW-1:0] raddr,
    output logic [31:0]    rdata
);
    logic [DESC_N-1:0][31:0] tbl_q;

    always_ff @(posedge clk) begin
        if (rst)     tbl_q <= '0;
        else if (we) tbl_q[waddr] <= wdata;
    end

    assign rdata = tbl_q[raddr];
endmodule

// File: rtl/vsx_regbanks.sv
module vsx_regbanks import vsx_pkg::*; #(
    parameter int N_IN  = 16,
    parameter int N_TMP = 16,
    parameter int N_UNI = 96,
    parameter int N_OUT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_we,
    input  logic [1:0]       ld_bank,
    input  logic [6:0]       ld_idx,
    input  vec_t             ld_data,
    input  logic             wr_en,
    input  logic             wr_tmp,
    input  logic [3:0]       wr_idx,
    input  logic [3:0]       wr_mask,
    input  vec_t             wr_data,
    input  logic [6:0]       src1_idx,
    output vec_t             src1,
    input  logic [4:0]       src2_idx,
    output vec_t             src2,
    input  logic             rd_bank,
    input  logic [3:0]       rd_idx,
    output vec_t             rd_data,
    output vec_t [N_OUT-1:0] out_all
);
    vec_t [N_IN-1:0]  in_q;
    vec_t [N_TMP-1:0] tmp_q;
    vec_t [N_UNI-1:0] uni_q;
    vec_t [N_OUT-1:0] out_q;
    logic [6:0]       uni_sel;

    assign uni_sel = src1_idx - 7'h20;

    always_comb begin
        if (src1_idx < 7'h10)        src1 = in_q[src1_idx[3:0]];
        else if (src1_idx < 7'h20)   src1 = tmp_q[src1_idx[3:0]];
        else if (uni_sel < 7'(N_UNI)) src1 = uni_q[uni_sel];
        else                         src1 = '0;
        src2    = src2_idx[4] ? tmp_q[src2_idx[3:0]] : in_q[src2_idx[3:0]];
        rd_data = rd_bank ? tmp_q[rd_idx] : out_q[rd_idx[2:0]];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_q  <= '0;
            tmp_q <= '0;
            uni_q <= '0;
            out_q <= '0;
        end else begin
            if (ld_we) begin
                case (ld_bank)
                    2'd0: in_q[ld_idx[3:0]]  <= ld_data;
                    2'd1: tmp_q[ld_idx[3:0]] <= ld_data;
                    2'd2: if (ld_idx < 7'(N_UNI)) uni_q[ld_idx] <= ld_data;
                    default: ;
                endcase
            end
            if (wr_en) begin
                for (int c = 0; c < NC; c++) begin
                    if (wr_mask[NC-1-c]) begin
                        if (wr_tmp) tmp_q[wr_idx][c]      <= wr_data[c];
                        else        out_q[wr_idx[2:0]][c] <= wr_data[c];
                    end
                end
            end
        end
    end

    assign out_all = out_q;
endmodule

// File: rtl/vsx_swizzle.sv
module vsx_swizzle import vsx_pkg::*; (
    input  vec_t          src,
    input  logic [2*NC-1:0] sel,
    input  logic          neg,
    output vec_t          dst
);
    for (genvar c = 0; c < NC; c++) begin : g_lane
        comp_t pick;
        assign pick   = src[sel[2*c +: 2]];
        assign dst[c] = neg ? sat_neg(pick) : pick;
    end
endmodule

// File: rtl/vsx_alu.sv
module vsx_alu import vsx_pkg::*; (
    input  op_e  op,
    input  vec_t a,
    input  vec_t b,
    output vec_t res
);
    comp_t d3;
    comp_t d4;

    always_comb begin
        d3 = dot(a, b, 3);
        d4 = dot(a, b, 4);
        for (int c = 0; c < NC; c++) begin
            case (op)
                OP_ADD: res[c] = sat_add(a[c], b[c]);
                OP_MUL: res[c] = sat_mul(a[c], b[c]);
                OP_MAX: res[c] = ($signed(a[c]) > $signed(b[c])) ? a[c] : b[c];
                OP_MIN: res[c] = ($signed(a[c]) < $signed(b[c])) ? a[c] : b[c];
                OP_MOV: res[c] = a[c];
                OP_DP3: res[c] = d3;
                OP_DP4: res[c] = d4;
                default: res[c] = '0;
            endcase
        end
    end
endmodule

// File: rtl/vshader_exec.sv
module vshader_exec import vsx_pkg::*; #(
    parameter int N_IN  = 16,
    parameter int N_TMP = 16,
    parameter int N_UNI = 96,
    parameter int N_OUT = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [31:0]    in_instr,
    input  logic           desc_we,
    input  logic [DAW-1:0] desc_addr,
    input  logic [31:0]    desc_wdata,
    input  logic           ld_we,
    input  logic [1:0]     ld_bank,
    input  logic [6:0]     ld_idx,
    input  logic [VW-1:0]  ld_data,
    input  logic           rd_bank,
    input  logic [3:0]     rd_idx,
    output logic [VW-1:0]  rd_data,
    output logic           done,
    output logic           illegal
);
    logic             accept;
    logic [31:0]      dword;
    vec_t             raw_a;
    vec_t             raw_b;
    vec_t             opa;
    vec_t             opb;
    vec_t             result;
    vec_t [N_OUT-1:0] out_view;
    issue_t           nxt;
    issue_t           s1_q;
    logic             s1_v;
    logic [4:0]       dst;
    logic [2*NC-1:0]  sel_a;
    logic [2*NC-1:0]  sel_b;
    logic             unused_bits;

    assign accept = in_valid && in_ready;
    assign dst    = in_instr[25:21];
    assign sel_a  = {dword[6:5], dword[8:7], dword[10:9], dword[12:11]};
    assign sel_b  = {dword[15:14], dword[17:16], dword[19:18], dword[21:20]};
    assign unused_bits = ^{in_instr[20:19], in_instr[6:5], dword[31:22], dword[13]};

    vsx_desc_table u_desc (
        .clk(clk), .rst(rst), .we(desc_we), .waddr(desc_addr), .wdata(desc_wdata),
        .raddr(in_instr[DAW-1:0]), .rdata(dword)
    );

    vsx_regbanks #(.N_IN(N_IN), .N_TMP(N_TMP), .N_UNI(N_UNI), .N_OUT(N_OUT)) u_banks (
        .clk(clk), .rst(rst),
        .ld_we(ld_we), .ld_bank(ld_bank), .ld_idx(ld_idx), .ld_data(ld_data),
        .wr_en(s1_v && !s1_q.bad), .wr_tmp(s1_q.dst_tmp), .wr_idx(s1_q.dst_idx),
        .wr_mask(s1_q.mask), .wr_data(result),
        .src1_idx(in_instr[18:12]), .src1(raw_a),
        .src2_idx(in_instr[11:7]), .src2(raw_b),
        .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data), .out_all(out_view)
    );

    vsx_swizzle u_swz_a (.src(raw_a), .sel(sel_a), .neg(dword[4]), .dst(opa));
    vsx_swizzle u_swz_b (.src(raw_b), .sel(sel_b), .neg(1'b0),     .dst(opb));

    always_comb begin
        nxt.op      = op_e'(in_instr[31:26]);
        nxt.a       = opa;
        nxt.b       = opb;
        nxt.mask    = dword[3:0];
        nxt.dst_tmp = dst[4];
        nxt.dst_idx = dst[3:0];
        nxt.bad     = !op_known(in_instr[31:26]) || (dst[4:3] == 2'b01);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v    <= 1'b0;
            s1_q    <= '0;
            done    <= 1'b0;
            illegal <= 1'b0;
        end else begin
            s1_v    <= accept;
            if (accept) s1_q <= nxt;
            done    <= s1_v;
            illegal <= s1_v && s1_q.bad;
        end
    end

    vsx_alu u_alu (.op(s1_q.op), .a(s1_q.a), .b(s1_q.b), .res(result));

    assign in_ready = !s1_v;
endmodule

// File: rtl/vsx_exec_chk.sv
module vsx_exec_chk import vsx_pkg::*; #(
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             done,
    input logic             illegal,
    input vec_t [N_OUT-1:0] outs
);
    assert_ready_gap_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    assert_done_latency_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(in_valid && in_ready, 2));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_illegal_with_done_R12: assert property (@(posedge clk) disable iff (rst)
        illegal |-> done);

    assert_illegal_no_write_R12: assert property (@(posedge clk) disable iff (rst)
        illegal |-> $stable(outs));
endmodule

bind vshader_exec vsx_exec_chk #(.N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .done(done), .illegal(illegal), .outs(out_view)
);

// File: tb/tb_vshader_exec.sv
module tb_vshader_exec;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_instr = '0;
    logic        desc_we = 1'b0;
    logic [4:0]  desc_addr = '0;
    logic [31:0] desc_wdata = '0;
    logic        ld_we = 1'b0;
    logic [1:0]  ld_bank = '0;
    logic [6:0]  ld_idx = '0;
    logic [95:0] ld_data = '0;
    logic        rd_bank = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [95:0] rd_data;
    logic        done;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    vshader_exec dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
        .desc_we(desc_we), .desc_addr(desc_addr), .desc_wdata(desc_wdata),
        .ld_we(ld_we), .ld_bank(ld_bank), .ld_idx(ld_idx), .ld_data(ld_data),
        .rd_bank(rd_bank), .rd_idx(rd_idx), .rd_data(rd_data),
        .done(done), .illegal(illegal)
    );

    localparam int NV = 10;
    localparam logic [31:0] V_DESC [NV] = '{
        32'h0006C36F, 32'h0006C36F, 32'h0006C36F, 32'h0006C36A, 32'h00001C9F,
        32'h0006C37F, 32'h003FC36F, 32'h0006C36F, 32'h0006C36F, 32'h0006C36F};
    localparam logic [31:0] V_INSTR [NV] = '{
        32'h02000080, 32'h20225081, 32'h08400002, 32'h04600083, 32'h4C800004,
        32'h30A02005, 32'h34C02006, 32'h00E02107, 32'h2227F11F, 32'h02401808};
    localparam logic V_TMP [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    localparam logic [3:0] V_IDX [NV] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd1, 4'd2};
    localparam logic [95:0] V_EXP [NV] = '{
        {24'h048000, 24'h038000, 24'h028000, 24'h018000},
        {24'h140000, 24'h0F0000, 24'h0A0000, 24'h050000},
        {24'h1E0000, 24'h1E0000, 24'h1E0000, 24'h1E0000},
        {24'h000000, 24'h030000, 24'h000000, 24'h030000},
        {24'hFF0000, 24'hFE0000, 24'hFD0000, 24'hFC0000},
        {24'h040000, 24'h030000, 24'h7FFFFF, 24'h010000},
        {24'h010000, 24'h010000, 24'h800000, 24'h040000},
        {24'h020000, 24'h020000, 24'h800000, 24'h7FFFFF},
        {24'h640000, 24'h640000, 24'h800000, 24'h7FFFFF},
        {24'h050000, 24'h040000, 24'h030000, 24'h020000}};
    localparam string V_REQ [NV] = '{
        "R1 R8 add", "R2 uniform mul", "R9 dp4", "R6 R9 dp3 mask", "R5 R7 mov",
        "R7 R8 max neg", "R5 R8 min bcast", "R8 add sat", "R2 R8 mul sat", "R2 src2 temp"};

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] bank, input logic [6:0] idx, input logic [95:0] data);
        @(negedge clk);
        ld_we = 1'b1; ld_bank = bank; ld_idx = idx; ld_data = data;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic wdesc(input logic [4:0] idx, input logic [31:0] word);
        @(negedge clk);
        desc_we = 1'b1; desc_addr = idx; desc_wdata = word;
        @(posedge clk);
    endtask

    task automatic issue(input logic [31:0] instr, output logic rdy_after,
                         output logic d1, output logic d2, output logic il);
        @(negedge clk);
        desc_we = 1'b0;
        in_valid = 1'b1; in_instr = instr;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        rdy_after = in_ready;
        d1 = done;
        @(posedge clk);
        @(negedge clk);
        d2 = done;
        il = illegal;
    endtask

    task automatic readback(input logic bank, input logic [3:0] idx, output logic [95:0] val);
        rd_bank = bank; rd_idx = idx;
        #1;
        val = rd_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [95:0] v;
        logic ra, d1, d2, il;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R13 reset state
        check("R10 ready after reset", {95'd0, in_ready}, 96'd1);
        check("R11 done after reset", {94'd0, done, illegal}, 96'd0);
        readback(1'b0, 4'd0, v);
        check("R13 output cleared", v, 96'd0);

        load(2'd0, 7'd0, {24'h040000, 24'h030000, 24'h020000, 24'h010000});
        load(2'd0, 7'd1, {24'h008000, 24'h008000, 24'h008000, 24'h008000});
        load(2'd0, 7'd2, {24'h010000, 24'h010000, 24'h800000, 24'h7F0000});
        load(2'd2, 7'd5, {24'h280000, 24'h1E0000, 24'h140000, 24'h0A0000});
        load(2'd2, 7'd95, {24'h640000, 24'h640000, 24'h640000, 24'h640000});

        for (int i = 0; i < NV; i++) begin
            wdesc(V_INSTR[i][4:0], V_DESC[i]);  // R4: descriptor used one cycle later
            issue(V_INSTR[i], ra, d1, d2, il);
            check({V_REQ[i], " R10 ready low"}, {95'd0, ra}, 96'd0);
            check({V_REQ[i], " R11 done timing"}, {94'd0, d1, d2}, 96'd1);
            check({V_REQ[i], " R12 no flag"}, {95'd0, il}, 96'd0);
            readback(V_TMP[i], V_IDX[i], v);
            check({V_REQ[i], " R3 R4 result"}, v, V_EXP[i]);
        end

        // R12: unsupported opcode 0x0E aimed at output 0
        wdesc(5'd0, 32'h0006C36F);
        issue(32'h38000000, ra, d1, d2, il);
        check("R12 rcp flagged", {94'd0, d2, il}, 96'd3);
        readback(1'b0, 4'd0, v);
        check("R12 rcp no write", v, 96'd0);

        // R12: supported add into undefined destination 0x08
        issue(32'h01000000, ra, d1, d2, il);
        check("R12 dest 0x08 flagged", {94'd0, d2, il}, 96'd3);
        readback(1'b0, 4'd0, v);
        check("R12 dest 0x08 no write", v, 96'd0);

        // R12: opcode 0x3F aimed at temporary 0
        issue(32'hFE000000, ra, d1, d2, il);
        check("R12 op 0x3F flagged", {94'd0, d2, il}, 96'd3);
        readback(1'b1, 4'd0, v);
        check("R12 op 0x3F no write", v, {24'h048000, 24'h038000, 24'h028000, 24'h018000});

        // R1 R3: legal add into output 0 after rejected ones
        issue(32'h00000080, ra, d1, d2, il);
        readback(1'b0, 4'd0, v);
        check("R1 R3 add to out0", v, {24'h048000, 24'h038000, 24'h028000, 24'h018000});

        // R13: reset clears temporary bank
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        readback(1'b1, 4'd0, v);
        check("R13 temp cleared by reset", v, 96'd0);
        readback(1'b0, 4'd0, v);
        check("R13 output cleared by reset", v, 96'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule